// File: doc/BRIEF.md
# Four-Phase Interleaver Address Generator

This block produces, one per clock, the interleaved addresses of a four-phase almost-regular permutation of the kind used by duo-binary turbo codes. A single start pulse carries the block length N (the number of symbol couples) and four permutation parameters. From the next cycle the block emits N addresses, for indices j = 0 up to N-1, with a valid flag on every address and a last flag on the final one.

The address for index j is (P0*j + 1 + offset) mod N. The offset depends on j mod 4. Phase 0 adds nothing. Phase 2 adds P2. The odd phases add N/2 together with P1 (phase 1) or P3 (phase 3). No multiplier or divider is used. A running base value (P0*j + 1) mod N advances by P0 through one addition and one conditional subtraction. The four offsets are reduced modulo N once, when the block starts. Each output is then the base plus the offset of the current phase, followed by one conditional subtraction.

N must be even and between 2 and 2^AW - 2. P0 to P3 must already be below N. Deriving the parameters from the block size is left to the surrounding logic.

Top module: `arp_addr_gen`

## Requirements
- R1: After reset, and until a start is accepted, addr_valid and addr_last are low.
- R2: A start pulse that is accepted is followed, from the next cycle, by exactly N consecutive cycles with addr_valid high, one for each j = 0 to N-1 in increasing order. No further valid cycle follows unless another start is accepted.
- R3: When j mod 4 = 0, addr equals (P0*j + 1) mod N.
- R4: When j mod 4 = 1, addr equals (P0*j + 1 + N/2 + P1) mod N.
- R5: When j mod 4 = 2, addr equals (P0*j + 1 + P2) mod N.
- R6: When j mod 4 = 3, addr equals (P0*j + 1 + N/2 + P3) mod N.
- R7: addr_last is high exactly in the valid cycle for j = N-1, and never when addr_valid is low.
- R8: A start asserted while the block is producing addresses, in any cycle other than the last-address cycle, is ignored. The sequence in progress continues unchanged, using the N and parameters captured at its own start.
- R9: A start asserted in the last-address cycle is accepted. The new sequence begins in the next cycle with no gap.
- R10: Every valid address is below N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request; captures n_len and p0..p3 when accepted |
| n_len | input | AW | Block length N, even |
| p0 | input | AW | Linear step of the permutation |
| p1 | input | AW | Extra offset for phase 1 |
| p2 | input | AW | Extra offset for phase 2 |
| p3 | input | AW | Extra offset for phase 3 |
| addr | output | AW | Interleaved address for the current index |
| addr_valid | output | 1 | addr holds a valid address |
| addr_last | output | 1 | The current address is for j = N-1 |

## Verification
The case that is hardest to reach from the ports is a start that lands in the last-address cycle, because the new block has to take over in the very next cycle. To hit that cycle exactly, the stimulus waits until it sees addr_last high and then raises start at once, so the request meets the same clock edge that ends the old block. The wrap-around paths are driven too. Large P0 values make the base wrap on nearly every step, and P1 or P3 above N/2 make the odd-phase offset sum pass N. Starts raised in the middle of a block carry different parameters, so an accidental restart shows up as wrong addresses.

// File: rtl/arp_addr_gen.sv
module arp_addr_gen #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] n_len,
  input  logic [AW-1:0] p0,
  input  logic [AW-1:0] p1,
  input  logic [AW-1:0] p2,
  input  logic [AW-1:0] p3,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic          addr_last
);

  function automatic logic [AW-1:0] modn(input logic [AW:0] s, input logic [AW-1:0] m);
    logic [AW:0] d;
    d = s - {1'b0, m};
    return (s >= {1'b0, m}) ? d[AW-1:0] : s[AW-1:0];
  endfunction

  logic          busy;
  logic [AW-1:0] n_q, p0_q, base_q, idx_q;
  logic [1:0]    ph_q;
  logic [AW-1:0] off_q [4];
  logic [AW-1:0] off_d [4];
  logic [AW-1:0] half;
  logic          accept;

  assign half   = n_len >> 1;
  assign off_d[0] = '0;
  assign off_d[1] = modn({1'b0, half} + {1'b0, p1}, n_len);
  assign off_d[2] = p2;
  assign off_d[3] = modn({1'b0, half} + {1'b0, p3}, n_len);

  assign addr_valid = busy;
  assign addr_last  = busy && (idx_q == n_q - AW'(1));
  assign accept     = start && (!busy || addr_last);
  assign addr       = modn({1'b0, base_q} + {1'b0, off_q[ph_q]}, n_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      n_q    <= '0;
      p0_q   <= '0;
      base_q <= '0;
      idx_q  <= '0;
      ph_q   <= '0;
      for (int k = 0; k < 4; k++) off_q[k] <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      n_q    <= n_len;
      p0_q   <= p0;
      base_q <= AW'(1);
      idx_q  <= '0;
      ph_q   <= '0;
      for (int k = 0; k < 4; k++) off_q[k] <= off_d[k];
    end else if (busy) begin
      if (addr_last) begin
        busy <= 1'b0;
      end else begin
        base_q <= modn({1'b0, base_q} + {1'b0, p0_q}, n_q);
        idx_q  <= idx_q + AW'(1);
        ph_q   <= ph_q + 2'd1;
      end
    end
  end

endmodule

// File: rtl/arp_addr_gen_chk.sv
module arp_addr_gen_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] addr,
  input logic          addr_valid,
  input logic          addr_last,
  input logic [AW-1:0] n_q
);

  logic [AW-1:0] cnt;
  logic          acc;
  assign acc = start && (!addr_valid || addr_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (acc)        cnt <= '0;
    else if (addr_valid) cnt <= cnt + AW'(1);
  end

  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !addr_valid) |=> addr_valid);
  p_no_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_last) |=> addr_valid);
  p_last_has_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_last |-> addr_valid);
  p_last_position_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr_last == (cnt == n_q - AW'(1))));
  p_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_last && !start) |=> !addr_valid);
  p_keep_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_last) |=> $stable(n_q));
  p_b2b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_last && start) |=> (addr_valid && cnt == '0));
  p_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr < n_q));

endmodule

bind arp_addr_gen arp_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
  .addr_valid(addr_valid), .addr_last(addr_last), .n_q(n_q)
);

// File: tb/test_arp_addr_gen.sv
module test_arp_addr_gen;
  localparam int AW = 12;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] n_len = '0, p0 = '0, p1 = '0, p2 = '0, p3 = '0;
  logic [AW-1:0] addr;
  logic addr_valid, addr_last;

  int checks = 0, fails = 0, cycles = 0;
  int exp_addr[$];
  bit exp_last[$];
  int exp_ph[$];
  bit expect_follow = 0;
  bit prev_last = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arp_addr_gen #(.AW(AW)) i_arp_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len),
    .p0(p0), .p1(p1), .p2(p2), .p3(p3),
    .addr(addr), .addr_valid(addr_valid), .addr_last(addr_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic push_block(input int n, input int a0, input int a1, input int a2, input int a3);
    for (int j = 0; j < n; j++) begin
      longint v;
      v = longint'(a0) * j + 1;
      case (j % 4)
        1: v += n / 2 + a1;
        2: v += a2;
        3: v += n / 2 + a3;
        default: ;
      endcase
      exp_addr.push_back(int'(v % n));
      exp_last.push_back(j == n - 1);
      exp_ph.push_back(j % 4);
    end
  endtask

  task automatic drive_start(input int n, input int a0, input int a1, input int a2, input int a3);
    n_len = AW'(n); p0 = AW'(a0); p1 = AW'(a1); p2 = AW'(a2); p3 = AW'(a3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_block(input int n, input int a0, input int a1, input int a2, input int a3);
    push_block(n, a0, a1, a2, a3);
    drive_start(n, a0, a1, a2, a3);
  endtask

  task automatic wait_drained();
    while (exp_addr.size() != 0 || addr_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    check(!addr_valid, "R2 no valid after block", addr_valid, 0);
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (expect_follow && prev_last) begin
        check(addr_valid, "R9 next block without gap", addr_valid, 1);
        expect_follow = 0;
      end
      if (addr_valid) begin
        if (exp_addr.size() == 0) begin
          check(0, "R2 unexpected valid address", addr, -1);
        end else begin
          int ea, ph;
          bit el;
          ea = exp_addr.pop_front();
          el = exp_last.pop_front();
          ph = exp_ph.pop_front();
          case (ph)
            0: check(addr == ea, "R3 phase 0 address", addr, ea);
            1: check(addr == ea, "R4 phase 1 address", addr, ea);
            2: check(addr == ea, "R5 phase 2 address", addr, ea);
            default: check(addr == ea, "R6 phase 3 address", addr, ea);
          endcase
          check(addr_last == el, "R7 last flag", addr_last, el);
        end
      end else begin
        check(!addr_last, "R7 last without valid", addr_last, 0);
      end
      prev_last = addr_valid && addr_last;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!addr_valid && !addr_last, "R1 reset state", {addr_valid, addr_last}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!addr_valid, "R1 idle after reset", addr_valid, 0);

    run_block(24, 5, 3, 7, 11);
    wait_drained();

    run_block(240, 13, 200, 239, 119);
    wait_drained();

    run_block(2, 1, 1, 0, 1);
    wait_drained();

    run_block(4094, 4093, 4000, 4093, 2100);
    wait_drained();

    run_block(40, 9, 25, 30, 39);
    repeat (5) @(negedge clk);
    drive_start(100, 3, 1, 2, 3);
    repeat (10) @(negedge clk);
    drive_start(10, 1, 0, 0, 0);
    wait_drained();
    check(exp_addr.size() == 0, "R8 mid-block start ignored", exp_addr.size(), 0);

    run_block(48, 7, 30, 5, 47);
    while (!addr_last) @(negedge clk);
    expect_follow = 1;
    run_block(36, 11, 20, 35, 1);
    wait_drained();
    check(!expect_follow, "R9 follow-on check made", expect_follow, 0);

    run_block(1000, 999, 999, 998, 999);
    wait_drained();

    finish_run();
  end
endmodule